// File: doc/BRIEF.md
# Halt mode clock sequencer

This controller moves a processor between normal execution and a deep, minimum-power halt. While the processor runs, every clock and analog enable is on. A halt request starts a short drain window in which the core clock keeps running so the pipeline and outstanding transactions can finish. After that window the core and peripheral clocks are gated and the PLL and crystal oscillator are powered down.

Leaving halt is a two-phase handshake on one active-low wake pin. A falling edge is caught asynchronously and powers the oscillator back up. The later rising edge, accepted only once the oscillator reports ready, starts a fixed PLL lock count. A resume latency follows. Its length depends on whether the processor restarts from sleeping flash or from on-chip RAM. During that latency the core clock is already on, so a pending enabled interrupt can be taken. After the latency the sequencer returns to normal running.

The oscillator and PLL are not modelled as analog parts. They are represented by their enable lines, and all waits are counted on the single reference clock `clk`.

Top module: `halt_clk_seq`

## Requirements
- R1: After reset the block is in the run state. `run`, `core_clk_en`, `periph_clk_en`, `pll_en` and `osc_en` are all 1.
- R2: A `halt_req` sampled high in the run state starts the drain window. In the window `run` is 0 while `core_clk_en`, `periph_clk_en`, `pll_en` and `osc_en` stay 1. The window lasts exactly FLUSH_CYC cycles (default 32, legal range 32 to 45).
- R3: After the drain window the block is halted. All five outputs are 0, and they stay 0 until a wake falling edge arrives.
- R4: A falling edge on `wake_n` while halted is caught asynchronously. Within 4 clock cycles the block enters oscillator start-up, where only `osc_en` is 1.
- R5: During oscillator start-up, a rising edge of `wake_n` that arrives while `osc_ready` is 0 is ignored. The block stays in start-up until a rising edge is seen with `osc_ready` at 1.
- R6: A rising edge accepted in start-up begins PLL lock. In this phase `osc_en` and `pll_en` are 1 and the other outputs are 0. The phase lasts exactly LOCK_CYC cycles.
- R7: The wake latency follows PLL lock. In this phase `osc_en`, `pll_en` and `core_clk_en` are 1, while `periph_clk_en` and `run` are 0. It lasts LAT_RAM cycles when `boot_ram` is 1 at the end of PLL lock, and LAT_FLASH cycles when `boot_ram` is 0.
- R8: At the end of the wake latency the block returns to the run state with all five outputs at 1.
- R9: `halt_req` has no effect during oscillator start-up, PLL lock and wake latency.
- R10: `halt_req` has no effect while halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all counts use it |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Request to enter halt, sampled in the run state |
| wake_n | input | 1 | Active-low wake pin: falling edge starts the oscillator, rising edge starts PLL lock |
| osc_ready | input | 1 | Oscillator has stabilised |
| boot_ram | input | 1 | 1 = resume from on-chip RAM, 0 = resume from sleeping flash |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pll_en | output | 1 | PLL power enable |
| osc_en | output | 1 | Crystal oscillator power enable |
| run | output | 1 | High only in normal running |

## Verification
The hardest case to reach is oscillator start-up with a wake rising edge that comes too early. Reaching it needs a full halt entry, an asynchronous falling edge and a rising edge while `osc_ready` is still low. After that, a second falling and rising pair must follow before PLL lock may begin. The random stimulus covers this in several ways: it halts repeatedly, varies the dwell time in halt, and, chosen at random per round, raises the wake pin before the ready indication. It also holds `halt_req` high through the wake-up phases and varies `boot_ram`. The length of each phase is then measured at the ports.

// File: rtl/halt_clk_seq.sv
module halt_clk_seq #(
  parameter int FLUSH_CYC = 32,
  parameter int LOCK_CYC  = 131072,
  parameter int LAT_FLASH = 1125,
  parameter int LAT_RAM   = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_req,
  input  logic wake_n,
  input  logic osc_ready,
  input  logic boot_ram,
  output logic core_clk_en,
  output logic periph_clk_en,
  output logic pll_en,
  output logic osc_en,
  output logic run
);
  localparam int M1   = (LOCK_CYC > LAT_FLASH) ? LOCK_CYC : LAT_FLASH;
  localparam int M2   = (M1 > LAT_RAM) ? M1 : LAT_RAM;
  localparam int MAXC = (M2 > FLUSH_CYC) ? M2 : FLUSH_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    RUN, FLUSH, HALTED, OSC_START, PLL_LOCK, WAKE_LAT
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lat_last;
  logic          clr_q, wk_clr, pend;
  logic          pend_s1, pend_s2;
  logic          wk_s1, wk_s2, wk_s3;
  logic          wk_rise;

  assign wk_clr = ~rst_n | clr_q;

  always_ff @(negedge wake_n or posedge wk_clr)
    if (wk_clr) pend <= 1'b0;
    else        pend <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {pend_s1, pend_s2} <= 2'b00;
      {wk_s1, wk_s2, wk_s3} <= 3'b111;
      clr_q <= 1'b1;
    end else begin
      pend_s1 <= pend;
      pend_s2 <= pend_s1;
      wk_s1   <= wake_n;
      wk_s2   <= wk_s1;
      wk_s3   <= wk_s2;
      clr_q   <= (state != HALTED);
    end

  assign wk_rise = wk_s2 & ~wk_s3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= RUN;
      cnt      <= '0;
      lat_last <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      case (state)
        RUN: begin
          cnt <= '0;
          if (halt_req) state <= FLUSH;
        end
        FLUSH:
          if (cnt == CW'(FLUSH_CYC - 1)) begin
            state <= HALTED;
            cnt   <= '0;
          end
        HALTED: begin
          cnt <= '0;
          if (pend_s2 && !clr_q) state <= OSC_START;
        end
        OSC_START: begin
          cnt <= '0;
          if (wk_rise && osc_ready) state <= PLL_LOCK;
        end
        PLL_LOCK:
          if (cnt == CW'(LOCK_CYC - 1)) begin
            state    <= WAKE_LAT;
            cnt      <= '0;
            lat_last <= boot_ram ? CW'(LAT_RAM - 1) : CW'(LAT_FLASH - 1);
          end
        WAKE_LAT:
          if (cnt == lat_last) begin
            state <= RUN;
            cnt   <= '0;
          end
        default: state <= RUN;
      endcase
    end

  assign run           = (state == RUN);
  assign periph_clk_en = (state == RUN) || (state == FLUSH);
  assign core_clk_en   = periph_clk_en || (state == WAKE_LAT);
  assign pll_en        = core_clk_en || (state == PLL_LOCK);
  assign osc_en        = pll_en || (state == OSC_START);
endmodule

// File: rtl/halt_clk_seq_chk.sv
module halt_clk_seq_chk #(
  parameter int FLUSH_CYC = 32
) (
  input logic clk,
  input logic rst_n,
  input logic core_clk_en,
  input logic periph_clk_en,
  input logic pll_en,
  input logic osc_en,
  input logic run
);
  int flush_n;
  logic in_flush;
  assign in_flush = periph_clk_en && !run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flush_n <= 0;
    else        flush_n <= in_flush ? flush_n + 1 : 0;

  p_run_all_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (core_clk_en && periph_clk_en && pll_en && osc_en));

  p_flush_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flush_n <= FLUSH_CYC);

  p_halt_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!pll_en && !core_clk_en && !periph_clk_en && !run));

  p_osc_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> (!pll_en && !core_clk_en));

  p_pll_on_osc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en |-> osc_en);

  p_core_on_pll_r7: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en |-> pll_en);

  p_run_after_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ($past(core_clk_en) && !$past(periph_clk_en)));

  p_no_flush_in_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && !periph_clk_en) |=> !(periph_clk_en && !run));
endmodule

bind halt_clk_seq halt_clk_seq_chk #(.FLUSH_CYC(FLUSH_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_clk_en(core_clk_en),
  .periph_clk_en(periph_clk_en), .pll_en(pll_en), .osc_en(osc_en), .run(run)
);

// File: tb/halt_clk_seq_tb_top.sv
module halt_clk_seq_tb_top;
  localparam int PERIOD = 10;
  localparam int FL  = 32;
  localparam int LK  = 200;
  localparam int LF  = 60;
  localparam int LR  = 7;

  localparam int C_RUN = 0, C_FLUSH = 1, C_HALT = 2, C_OSC = 3, C_PLL = 4, C_LAT = 5, C_BAD = 7;

  logic clk = 0, rst_n = 1, halt_req = 0, wake_n = 1, osc_ready = 0, boot_ram = 0;
  logic core_clk_en, periph_clk_en, pll_en, osc_en, run;
  int checks = 0, fails = 0;
  bit done = 0;

  halt_clk_seq #(.FLUSH_CYC(FL), .LOCK_CYC(LK), .LAT_FLASH(LF), .LAT_RAM(LR)) dut_i (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wake_n(wake_n),
    .osc_ready(osc_ready), .boot_ram(boot_ram), .core_clk_en(core_clk_en),
    .periph_clk_en(periph_clk_en), .pll_en(pll_en), .osc_en(osc_en), .run(run)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic int decode(logic c, logic p, logic l, logic o, logic r);
    case ({c, p, l, o, r})
      5'b11111: return C_RUN;
      5'b11110: return C_FLUSH;
      5'b00000: return C_HALT;
      5'b00010: return C_OSC;
      5'b00110: return C_PLL;
      5'b10110: return C_LAT;
      default:  return C_BAD;
    endcase
  endfunction

  function automatic int exp_lat(logic ram);
    return ram ? LR : LF;
  endfunction

  function automatic int cur();
    return decode(core_clk_en, periph_clk_en, pll_en, osc_en, run);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_state(int code, output int n);
    n = 0;
    while (cur() == code && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_for(int code, int limit, output int n);
    n = 0;
    while (cur() != code && n < limit) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic round(bit early, bit hold_halt, logic ram, int dwell);
    int n;
    @(negedge clk);
    halt_req = 1;
    @(negedge clk);
    halt_req = 0;
    check(cur() == C_FLUSH, "R2 enter drain", cur(), C_FLUSH);
    count_state(C_FLUSH, n);
    check(n == FL, "R2 drain length", n, FL);
    check(cur() == C_HALT, "R3 halted outputs", cur(), C_HALT);
    for (int i = 0; i < dwell; i++) begin
      halt_req = (i % 2 == 0);
      @(negedge clk);
    end
    halt_req = 0;
    check(cur() == C_HALT, "R10 halt_req ignored while halted", cur(), C_HALT);
    osc_ready = 0;
    boot_ram  = ram;
    halt_req  = hold_halt;
    wake_n    = 0;
    wait_for(C_OSC, 4, n);
    check(cur() == C_OSC, "R4 osc start-up after fall", cur(), C_OSC);
    repeat (3) @(negedge clk);
    if (early) begin
      wake_n = 1;
      repeat (6) @(negedge clk);
      check(cur() == C_OSC, "R5 early rise ignored", cur(), C_OSC);
      osc_ready = 1;
      repeat (3) @(negedge clk);
      check(cur() == C_OSC, "R5 still waiting for fresh rise", cur(), C_OSC);
      wake_n = 0;
      repeat (3) @(negedge clk);
    end
    osc_ready = 1;
    @(negedge clk);
    wake_n = 1;
    wait_for(C_PLL, 6, n);
    check(cur() == C_PLL, "R6 lock phase entered", cur(), C_PLL);
    count_state(C_PLL, n);
    check(n == LK, "R6 lock length", n, LK);
    check(cur() == C_LAT, "R9 R7 latency after lock", cur(), C_LAT);
    halt_req = 0;
    count_state(C_LAT, n);
    check(n == exp_lat(ram), "R7 latency length", n, exp_lat(ram));
    check(cur() == C_RUN, "R8 back to run", cur(), C_RUN);
    osc_ready = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #1 rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(cur() == C_RUN, "R1 reset state", cur(), C_RUN);
    round(1'b0, 1'b0, 1'b1, 3);
    round(1'b1, 1'b1, 1'b0, 10);
    round(1'b0, 1'b1, 1'b0, 5);
    round(1'b1, 1'b0, 1'b1, 17);
    for (int k = 0; k < 6; k++)
      round(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 2 + int'($urandom % 20));
    repeat (5) @(negedge clk);
    check(cur() == C_RUN, "R8 stays running", cur(), C_RUN);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule